// File: doc/BRIEF.md
# Line Miss Refill Controller

This block sits between a requester and the storage of a small direct-mapped cache. It owns the tag, valid and dirty state and the line data. Each lookup is handled in a fixed order. A hit answers at once. A miss stalls the requester, picks the single line at the request's index as the victim, and streams that line out to the next memory level if it holds modified data. It then asks the next level for the missing line, takes the returned words one bus beat at a time, installs the new tag, and finally replays the original access, which now hits.

The memory side uses a single-cycle request pulse followed by a fixed-latency stream of read beats. Each beat is held for several cycles. Writeback beats leave the block in the same held-beat format. Only one miss is ever in flight, so the requester waits on `req_ready` before presenting the next access. Every phase of the miss path lasts a known number of cycles, so the whole penalty can be predicted to the cycle.

Top module: `line_refill_ctrl`

## Requirements
- R1: After reset every line is invalid and not dirty, `req_ready` is 1, and `miss_stall`, `resp_valid`, `mem_req` and `mem_wvalid` are 0, so the first access to any line misses.
- R2: A word address splits into offset bits [1:0], index bits [3:2] and tag bits [11:4]. A read accepted on clock edge e0 (with `req_valid` high while `req_ready` is 1) that hits gives `resp_valid` high for exactly one cycle, in the second cycle after e0, with the stored word on `resp_rdata`.
- R3: A write hit has the same response timing as R2. It stores `req_wdata` into the addressed word, returns that word on `resp_rdata`, and marks the line dirty.
- R4: On a miss, `miss_stall` rises in the cycle after the lookup cycle (cycle 2 after e0). It stays high without a gap through the fill cycle, and `req_ready` is 0 from cycle 1 until the response cycle.
- R5: With a clean or invalid victim, no writeback beat is sent. `mem_req` is high for one cycle, in cycle 3 after e0, with `mem_addr` = {request tag, index}.
- R6: With a valid dirty victim, `mem_wvalid` is high for LINE_WORDS*BEAT_CYC consecutive cycles starting in cycle 3. Victim word i is on `mem_wdata` for BEAT_CYC cycles, in offset order from 0. `mem_addr` = {victim tag, index} throughout. `mem_req` follows in the cycle after the last writeback cycle.
- R7: The refill takes each word from `mem_rdata` on the last cycle of every BEAT_CYC-cycle run of `mem_rvalid`, in offset order from 0. The fill cycle is the cycle right after the last captured beat. With a 10-cycle latency and 4 beats of 2 cycles, the span from the request cycle to the fill cycle, counted inclusively, is 19 cycles.
- R8: After the fill cycle the access is replayed as a lookup and hits. A clean miss responds in cycle 23 after e0, and a dirty-victim miss responds in cycle 31.
- R9: A refill leaves the line clean. A write miss allocates the line, and the replayed write then marks it dirty, so a later eviction writes the new word back.
- R10: While `req_ready` is 0, requests are ignored: they produce no response, no memory traffic and no change to any line.
- R11: Two addresses with the same index and different tags share one line, and each evicts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address {tag, index, offset} |
| req_wdata | input | WORD_W | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| miss_stall | output | 1 | Miss in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | WORD_W | Read word, or the written word on a write |
| mem_req | output | 1 | One-cycle line read request |
| mem_addr | output | ADDR_W-2 | Line address for a read request or a writeback |
| mem_wvalid | output | 1 | Writeback beat present |
| mem_wdata | output | WORD_W | Writeback beat data |
| mem_rvalid | input | 1 | Refill beat present, held BEAT_CYC cycles per beat |
| mem_rdata | input | WORD_W | Refill beat data |

## Verification
The bench tracks a behavioural copy of the cache and of the next memory level, and checks every output every cycle against the phase that copy predicts. It forces clean misses, dirty evictions on a shared index, a write miss followed by the eviction of the line it dirtied, and requests raised in the middle of a miss. A design that skipped the writeback, or sent it for a clean line, would put traffic on the wrong cycles, and a later refill would return stale data. A beat counter that is off by one would shift the response away from cycle 23 or 31. A controller that accepted a request while busy would give an extra response or start an extra memory request.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_VICTIM,
        ST_WBACK,
        ST_RDREQ,
        ST_RWAIT,
        ST_FILL
    } ctl_state_e;
endpackage

// File: rtl/lrc_tag_store.sv
module lrc_tag_store #(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (mark_dirty) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_tag
        always_ff @(posedge clk) begin
            if (fill_en && (idx == IDX_W'(i))) begin
                tag_q[i] <= fill_tag;
            end
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];
endmodule

// File: rtl/lrc_line_store.sv
module lrc_line_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
    import lrc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 4,
    parameter int BEAT_CYC   = 2,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int LADDR_W   = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               miss_stall,
    output logic               resp_valid,
    output logic [WORD_W-1:0]  resp_rdata,
    output logic               mem_req,
    output logic [LADDR_W-1:0] mem_addr,
    output logic               mem_wvalid,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata
);
    localparam int SUB_W = (BEAT_CYC > 1) ? $clog2(BEAT_CYC) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(BEAT_CYC - 1);
    localparam logic [OFF_W-1:0] BEAT_LAST = OFF_W'(LINE_WORDS - 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [WORD_W-1:0] wdata;
        logic [SUB_W-1:0]  sub;
        logic [OFF_W-1:0]  beat;
        logic              rsp;
        logic [WORD_W-1:0] rdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [OFF_W-1:0]  off;
    logic              line_valid, line_dirty, hit;
    logic [TAG_W-1:0]  line_tag;
    logic              fill_en, mark_dirty;
    logic [OFF_W-1:0]  rd_off, wr_off;
    logic [WORD_W-1:0] rd_data, wr_data;
    logic              wr_en;

    assign idx = c_q.addr[OFF_W +: IDX_W];
    assign tag = c_q.addr[ADDR_W-1 -: TAG_W];
    assign off = c_q.addr[OFF_W-1:0];
    assign hit = line_valid && (line_tag == tag);

    lrc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx),
        .fill_en    (fill_en),
        .fill_tag   (tag),
        .mark_dirty (mark_dirty),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    lrc_line_store #(.WORD_W(WORD_W), .DEPTH(NUM_LINES * LINE_WORDS)) u_data (
        .clk     (clk),
        .rd_addr ({idx, rd_off}),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr ({idx, wr_off}),
        .wr_data (wr_data)
    );

    always_comb begin
        c_d        = c_q;
        c_d.rsp    = 1'b0;
        wr_en      = 1'b0;
        wr_off     = off;
        wr_data    = c_q.wdata;
        rd_off     = off;
        fill_en    = 1'b0;
        mark_dirty = 1'b0;
        mem_req    = 1'b0;
        mem_wvalid = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.st    = ST_LOOKUP;
                    c_d.addr  = req_addr;
                    c_d.wr    = req_write;
                    c_d.wdata = req_wdata;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    c_d.st  = ST_IDLE;
                    c_d.rsp = 1'b1;
                    if (c_q.wr) begin
                        wr_en      = 1'b1;
                        mark_dirty = 1'b1;
                        c_d.rdata  = c_q.wdata;
                    end else begin
                        c_d.rdata  = rd_data;
                    end
                end else begin
                    c_d.st = ST_VICTIM;
                end
            end
            ST_VICTIM: begin
                c_d.sub  = '0;
                c_d.beat = '0;
                c_d.st   = (line_valid && line_dirty) ? ST_WBACK : ST_RDREQ;
            end
            ST_WBACK: begin
                mem_wvalid = 1'b1;
                rd_off     = c_q.beat;
                if (c_q.sub == SUB_LAST) begin
                    c_d.sub  = '0;
                    c_d.beat = c_q.beat + 1'b1;
                    if (c_q.beat == BEAT_LAST) c_d.st = ST_RDREQ;
                end else begin
                    c_d.sub = c_q.sub + 1'b1;
                end
            end
            ST_RDREQ: begin
                mem_req  = 1'b1;
                c_d.sub  = '0;
                c_d.beat = '0;
                c_d.st   = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (mem_rvalid) begin
                    if (c_q.sub == SUB_LAST) begin
                        wr_en    = 1'b1;
                        wr_off   = c_q.beat;
                        wr_data  = mem_rdata;
                        c_d.sub  = '0;
                        c_d.beat = c_q.beat + 1'b1;
                        if (c_q.beat == BEAT_LAST) c_d.st = ST_FILL;
                    end else begin
                        c_d.sub = c_q.sub + 1'b1;
                    end
                end
            end
            ST_FILL: begin
                fill_en = 1'b1;
                c_d.st  = ST_LOOKUP;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready  = (c_q.st == ST_IDLE);
    assign miss_stall = (c_q.st == ST_VICTIM) || (c_q.st == ST_WBACK) ||
                        (c_q.st == ST_RDREQ)  || (c_q.st == ST_RWAIT) ||
                        (c_q.st == ST_FILL);
    assign resp_valid = c_q.rsp;
    assign resp_rdata = c_q.rdata;
    assign mem_addr   = (c_q.st == ST_WBACK) ? {line_tag, idx} : {tag, idx};
    assign mem_wdata  = rd_data;
endmodule

// File: rtl/line_refill_ctrl_chk.sv
module line_refill_ctrl_chk #(
    parameter int WORD_W   = 32,
    parameter int BEAT_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              miss_stall,
    input logic              resp_valid,
    input logic              mem_req,
    input logic              mem_wvalid,
    input logic [WORD_W-1:0] mem_wdata
);
    a_r2_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r10_resp_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    a_r4_stall_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stall |-> !req_ready);

    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r5_req_inside_miss: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (miss_stall && !mem_wvalid));

    a_r6_wb_inside_miss: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> miss_stall);

    a_r6_wb_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((BEAT_CYC > 1) && $rose(mem_wvalid)) |=> (mem_wvalid && $stable(mem_wdata)));

    a_r8_replay_hits: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(miss_stall) |=> resp_valid);
endmodule

bind line_refill_ctrl line_refill_ctrl_chk #(.WORD_W(WORD_W), .BEAT_CYC(BEAT_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .miss_stall (miss_stall),
    .resp_valid (resp_valid),
    .mem_req    (mem_req),
    .mem_wvalid (mem_wvalid),
    .mem_wdata  (mem_wdata)
);

// File: tb/line_refill_ctrl_tb.sv
module line_refill_ctrl_tb;
    localparam int AW  = 12;
    localparam int WW  = 32;
    localparam int NB  = 4;
    localparam int BC  = 2;
    localparam int LAT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [WW-1:0] req_wdata = '0;
    logic          req_ready, miss_stall, resp_valid, mem_req, mem_wvalid;
    logic [WW-1:0] resp_rdata, mem_wdata;
    logic [AW-3:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [WW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    line_refill_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .miss_stall(miss_stall), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wvalid(mem_wvalid),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model of the next level and of the cache
    logic [WW-1:0] mem [logic [AW-1:0]];
    bit            m_valid [4];
    bit            m_dirty [4];
    logic [7:0]    m_tag [4];
    logic [WW-1:0] m_data [4][4];

    function automatic logic [WW-1:0] mem_word(logic [AW-1:0] wa);
        if (mem.exists(wa)) return mem[wa];
        return {16'hC0DE, 4'h0, wa};
    endfunction

    task automatic chk(string tag, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // next-level memory: fixed latency, BC cycles per beat
    int rd_k = -1;
    int wb_k = 0;
    logic [AW-3:0] rd_line = '0;
    always @(negedge clk) begin
        if (rd_k >= 0) rd_k++;
        if (rd_k >= LAT && rd_k < LAT + NB * BC) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem_word({rd_line, 2'((rd_k - LAT) / BC)});
        end else begin
            mem_rvalid = 1'b0;
        end
        if (rd_k >= LAT + NB * BC) rd_k = -1;
        if (mem_req) begin
            rd_k    = 0;
            rd_line = mem_addr;
        end
        if (mem_wvalid) begin
            mem[{mem_addr, 2'(wb_k / BC)}] = mem_wdata;
            wb_k++;
        end else begin
            wb_k = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R8 watchdog: actual %0d expected below 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [WW-1:0] wd,
                          input bit poke);
        logic [1:0]    idx, off;
        logic [7:0]    tg;
        logic [AW-3:0] vline, nline;
        logic [WW-1:0] wb [4];
        logic [WW-1:0] fw [4];
        logic [WW-1:0] exp_rd;
        bit            hit, dirty;
        int            rq_c, fill_c, resp_c;
        idx   = a[3:2];
        off   = a[1:0];
        tg    = a[11:4];
        hit   = m_valid[idx] && (m_tag[idx] == tg);
        dirty = !hit && m_valid[idx] && m_dirty[idx];
        vline = {m_tag[idx], idx};
        nline = {tg, idx};
        for (int b = 0; b < NB; b++) begin
            wb[b] = m_data[idx][b];
            fw[b] = mem_word({nline, 2'(b)});
        end
        rq_c   = dirty ? 3 + NB * BC : 3;
        fill_c = rq_c + LAT + NB * BC;
        resp_c = hit ? 2 : fill_c + 2;
        exp_rd = wr ? wd : (hit ? m_data[idx][off] : fw[off]);

        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        for (int k = 1; k <= resp_c + 1; k++) begin
            chk("R2", "resp_valid", 32'(resp_valid), 32'(k == resp_c));
            if (k == resp_c) chk(wr ? "R3" : "R8", "resp_rdata", resp_rdata, exp_rd);
            chk("R4", "miss_stall", 32'(miss_stall), 32'(!hit && k >= 2 && k <= fill_c));
            chk("R10", "req_ready", 32'(req_ready), 32'(k >= resp_c));
            chk("R5", "mem_req", 32'(mem_req), 32'(!hit && k == rq_c));
            if (!hit && k == rq_c) chk("R5", "read line addr", 32'(mem_addr), 32'(nline));
            chk("R6", "mem_wvalid", 32'(mem_wvalid), 32'(dirty && k >= 3 && k < rq_c));
            if (dirty && k >= 3 && k < rq_c) begin
                chk("R6", "wb data", mem_wdata, wb[(k - 3) / BC]);
                chk("R6", "wb line addr", 32'(mem_addr), 32'(vline));
            end
            if (k == 1) req_valid = 1'b0;
            if (poke && k == 2) begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = a ^ 12'h0A0;
                req_wdata = 32'hBAD0_0BAD;
            end
            if (k == fill_c) req_valid = 1'b0;
            @(negedge clk);
        end

        if (!hit) begin
            m_valid[idx] = 1'b1;
            m_dirty[idx] = 1'b0;
            m_tag[idx]   = tg;
            for (int b = 0; b < NB; b++) m_data[idx][b] = fw[b];
        end
        if (wr) begin
            m_data[idx][off] = wd;
            m_dirty[idx]     = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 1'b0;
            m_dirty[i] = 1'b0;
            m_tag[i]   = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "miss_stall", 32'(miss_stall), 32'd0);
        chk("R1", "resp_valid", 32'(resp_valid), 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "mem_wvalid", 32'(mem_wvalid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        access(1'b0, 12'h010, '0, 1'b0);           // R1 first touch misses, R7 refill
        access(1'b0, 12'h013, '0, 1'b0);           // R2 read hit
        access(1'b1, 12'h012, 32'hDEAD_BEEF, 1'b0); // R3 write hit
        access(1'b0, 12'h012, '0, 1'b0);           // R3 written word read back
        access(1'b0, 12'h020, '0, 1'b0);           // R11 same index, R6 dirty victim
        access(1'b0, 12'h012, '0, 1'b0);           // R9 clean victim, written-back word refilled
        chk("R6", "written-back word in next level", mem_word(12'h012), 32'hDEAD_BEEF);
        access(1'b1, 12'h035, 32'h1234_5678, 1'b0); // R9 write miss allocates
        access(1'b0, 12'h045, '0, 1'b0);           // R9 replayed write left the line dirty
        chk("R9", "write-miss word in next level", mem_word(12'h035), 32'h1234_5678);
        access(1'b0, 12'h0F8, '0, 1'b1);           // R10 requests ignored while busy
        for (int k = 0; k < 4; k++) begin
            chk("R10", "no stray response", 32'(resp_valid), 32'd0);
            chk("R10", "no stray request", 32'(mem_req), 32'd0);
            @(negedge clk);
        end
        access(1'b0, 12'h058, '0, 1'b0);           // R10 the ignored write touched nothing
        access(1'b0, 12'h0F9, '0, 1'b0);           // R11 index 2 was evicted
        access(1'b0, 12'h00C, '0, 1'b0);           // R1 index 3 first touch
        access(1'b0, 12'h00F, '0, 1'b0);           // R2 hit on index 3

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule